// File: doc/BRIEF.md
# Byte-Count Phase Barrier

This block holds a small array of completion barriers that count delivered bytes, not participants. A controller arms a slot by loading the number of bytes it expects. Data movers report finished transfers by presenting a slot index and a byte count on one of several arrival ports. The slot adds the counts to a running accumulator. When the accumulator reaches or passes the armed total, the slot flips its phase bit and starts the next round from zero. The armed total is kept, so the next round needs no re-arm.

A consumer waits on a slot by presenting the slot index and the phase parity it last saw. Its ready output rises once the slot's phase differs from that parity. Several transfers aimed at one slot add together, so one armed total can cover several pieces of one buffer. Arrivals on different ports in the same cycle also add together. The slot then flips only once every piece has landed.

Top module: `tcb_barrier`

## Requirements
- R1: A synchronous active-high reset sets every slot's phase to 0, accumulator to 0 and armed total to 0. After reset, a wait with parity 0 reports not ready and a wait with parity 1 reports ready, on every slot.
- R2: An arrival adds exactly its byte count to the addressed slot's accumulator. Completion therefore happens on the arrival that brings the sum to the total, and not one byte earlier.
- R3: When the accumulator plus the arriving bytes is greater than or equal to the armed total, the phase toggles and the accumulator becomes 0. Any excess is dropped. With a total of 0, any arrival completes the round.
- R4: `wait_ready` is high exactly when the phase of slot `wait_slot` differs from `wait_parity`. It rises in the cycle that follows the clock edge that captured the completing arrival, and stays low before that edge.
- R5: Arrivals to one slot accumulate across cycles. Arrivals on both ports to the same slot in the same cycle are summed before the completion test.
- R6: An arm stores the new total in the addressed slot and changes neither that slot's phase nor its accumulator.
- R7: If an arm and an arrival hit the same slot in one cycle, the arrival is tested against the old total first. The new total then applies from the next round.
- R8: A slot's armed total is kept across completions. Arrivals and arms to one slot leave all other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_valid | input | 1 | Load a new expected byte total |
| arm_slot | input | 3 | Slot to arm |
| arm_total | input | 20 | Expected byte total |
| arr_valid | input | 2 | One valid bit per arrival port |
| arr_slot | input | 6 | Slot index per port; port p uses bits [3p+2:3p] |
| arr_bytes | input | 40 | Byte count per port; port p uses bits [20p+19:20p] |
| wait_slot | input | 3 | Slot being waited on |
| wait_parity | input | 1 | Phase parity the waiter last observed |
| wait_ready | output | 1 | High when the slot's phase differs from `wait_parity` |

## Verification
A corrupted accumulator shows at the ports as a phase flip on the wrong arrival. The flip comes too early if bytes were over-counted, too late if they were lost, or carries a leftover into the next round. The first wait probe after the completing edge exposes it. A wrong total after an arm, or a same-cycle ordering error, moves the flip by a whole transfer. Sequences are therefore built so that the correct flip point differs from every wrong one by at least one arrival. A phase bit disturbed in a slot that was never addressed is caught by sweeping the wait port across all slots.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    localparam int ACC_W  = 20;
    localparam int NSLOTS = 8;
    localparam int SLOT_W = $clog2(NSLOTS);
    localparam int NPORTS = 2;
    localparam int SUM_W  = ACC_W + $clog2(NPORTS) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] total;
        logic             phase;
    } slot_state_t;

    function automatic logic round_done(input logic [SUM_W-1:0] sum,
                                        input logic [ACC_W-1:0] total);
        return sum >= {{(SUM_W-ACC_W){1'b0}}, total};
    endfunction

endpackage

// File: rtl/tcb_arrival_merge.sv
module tcb_arrival_merge
    import tcb_pkg::*;
#(
    parameter int P_NPORTS = NPORTS,
    parameter int P_NSLOTS = NSLOTS
) (
    input  logic [P_NPORTS-1:0]          arr_valid,
    input  logic [P_NPORTS*SLOT_W-1:0]   arr_slot,
    input  logic [P_NPORTS*ACC_W-1:0]    arr_bytes,
    output logic [P_NSLOTS-1:0]          slot_hit,
    output logic [P_NSLOTS*SUM_W-1:0]    slot_sum
);

    for (genvar s = 0; s < P_NSLOTS; s++) begin : g_slot
        logic [SUM_W-1:0] acc_sum;
        logic             any_hit;
        always_comb begin
            acc_sum = '0;
            any_hit = 1'b0;
            for (int p = 0; p < P_NPORTS; p++) begin
                if (arr_valid[p] && arr_slot[p*SLOT_W +: SLOT_W] == SLOT_W'(s)) begin
                    acc_sum = acc_sum + SUM_W'(arr_bytes[p*ACC_W +: ACC_W]);
                    any_hit = 1'b1;
                end
            end
        end
        assign slot_hit[s]                 = any_hit;
        assign slot_sum[s*SUM_W +: SUM_W]  = acc_sum;
    end

endmodule

// File: rtl/tcb_slot.sv
module tcb_slot
    import tcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arr_hit,
    input  logic [SUM_W-1:0] arr_sum,
    input  logic             arm_hit,
    input  logic [ACC_W-1:0] arm_total,
    output logic             phase
);

    slot_state_t st_q, st_d;
    logic [SUM_W-1:0] grown;

    always_comb begin
        st_d  = st_q;
        grown = SUM_W'(st_q.acc) + arr_sum;
        // arrival is judged against the total held before this cycle's arm
        if (arr_hit) begin
            if (round_done(grown, st_q.total)) begin
                st_d.phase = ~st_q.phase;
                st_d.acc   = '0;
            end else begin
                st_d.acc   = grown[ACC_W-1:0];
            end
        end
        if (arm_hit) begin
            st_d.total = arm_total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;

    // R3
    flip_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_hit && (SUM_W'(st_q.acc) + arr_sum) >= SUM_W'(st_q.total))
        |=> (st_q.phase != $past(st_q.phase)) && (st_q.acc == '0));

    // R2
    add_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_hit && (SUM_W'(st_q.acc) + arr_sum) < SUM_W'(st_q.total))
        |=> (st_q.acc == $past(st_q.acc) + $past(arr_sum[ACC_W-1:0])) && $stable(st_q.phase));

    // R6
    arm_load_chk: assert property (@(posedge clk) disable iff (rst)
        arm_hit |=> st_q.total == $past(arm_total));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!arr_hit && !arm_hit) |=> $stable(st_q));

endmodule

// File: rtl/tcb_barrier.sv
module tcb_barrier
    import tcb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      arm_valid,
    input  logic [SLOT_W-1:0]         arm_slot,
    input  logic [ACC_W-1:0]          arm_total,
    input  logic [NPORTS-1:0]         arr_valid,
    input  logic [NPORTS*SLOT_W-1:0]  arr_slot,
    input  logic [NPORTS*ACC_W-1:0]   arr_bytes,
    input  logic [SLOT_W-1:0]         wait_slot,
    input  logic                      wait_parity,
    output logic                      wait_ready
);

    logic [NSLOTS-1:0]       hit;
    logic [NSLOTS*SUM_W-1:0] sums;
    logic [NSLOTS-1:0]       phases;

    tcb_arrival_merge #(.P_NPORTS(NPORTS), .P_NSLOTS(NSLOTS)) u_merge (
        .arr_valid (arr_valid),
        .arr_slot  (arr_slot),
        .arr_bytes (arr_bytes),
        .slot_hit  (hit),
        .slot_sum  (sums)
    );

    for (genvar s = 0; s < NSLOTS; s++) begin : g_cell
        tcb_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .arr_hit   (hit[s]),
            .arr_sum   (sums[s*SUM_W +: SUM_W]),
            .arm_hit   (arm_valid && arm_slot == SLOT_W'(s)),
            .arm_total (arm_total),
            .phase     (phases[s])
        );
    end

    assign wait_ready = phases[wait_slot] ^ wait_parity;

    // R1
    reset_phase_chk: assert property (@(posedge clk)
        rst |=> phases == '0);

endmodule

// File: tb/sim_tcb_barrier.sv
module sim_tcb_barrier;

    logic        clk = 1'b0;
    logic        rst;
    logic        arm_valid;
    logic [2:0]  arm_slot;
    logic [19:0] arm_total;
    logic [1:0]  arr_valid;
    logic [5:0]  arr_slot;
    logic [39:0] arr_bytes;
    logic [2:0]  wait_slot;
    logic        wait_parity;
    logic        wait_ready;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    tcb_barrier u0 (
        .clk(clk), .rst(rst),
        .arm_valid(arm_valid), .arm_slot(arm_slot), .arm_total(arm_total),
        .arr_valid(arr_valid), .arr_slot(arr_slot), .arr_bytes(arr_bytes),
        .wait_slot(wait_slot), .wait_parity(wait_parity), .wait_ready(wait_ready)
    );

    // {kind[1:0] (0 arm, 1 port0, 2 port1), slot[2:0], value[19:0], expected phase}
    localparam logic [25:0] VEC [15] = '{
        {2'd0, 3'd0, 20'd100,     1'b0},
        {2'd1, 3'd0, 20'd60,      1'b0},
        {2'd2, 3'd0, 20'd39,      1'b0},
        {2'd1, 3'd0, 20'd1,       1'b1},
        {2'd1, 3'd0, 20'd99,      1'b1},
        {2'd2, 3'd0, 20'd5,       1'b0},
        {2'd1, 3'd0, 20'd99,      1'b0},
        {2'd1, 3'd0, 20'd1,       1'b1},
        {2'd0, 3'd3, 20'd20,      1'b0},
        {2'd2, 3'd3, 20'd25,      1'b1},
        {2'd1, 3'd5, 20'd1000,    1'b1},
        {2'd0, 3'd2, 20'hFFFFF,   1'b0},
        {2'd1, 3'd2, 20'hFFFF0,   1'b0},
        {2'd2, 3'd2, 20'h0000E,   1'b0},
        {2'd1, 3'd2, 20'd1,       1'b1}
    };

    task automatic idle();
        arm_valid = 1'b0; arm_slot = '0; arm_total = '0;
        arr_valid = '0;   arr_slot = '0; arr_bytes = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0b exp=%0b", req, got, exp);
        end
    endtask

    task automatic probe(input logic [2:0] s, input logic par, output logic r);
        wait_slot = s; wait_parity = par;
        #1;
        r = wait_ready;
    endtask

    task automatic chk_phase(input logic [2:0] s, input logic exp, input string req);
        logic r;
        probe(s, 1'b0, r);
        check(r, exp, req);
    endtask

    // drive both ports (and optionally an arm) in one cycle
    task automatic cycle_ops(input logic a_v, input logic [2:0] a_s, input logic [19:0] a_t,
                             input logic [1:0] v, input logic [2:0] s0, input logic [19:0] b0,
                             input logic [2:0] s1, input logic [19:0] b1);
        arm_valid = a_v; arm_slot = a_s; arm_total = a_t;
        arr_valid = v; arr_slot = {s1, s0}; arr_bytes = {b1, b0};
        tick();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic r;
        idle();
        wait_slot = '0; wait_parity = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state on every slot
        for (int s = 0; s < 8; s++) begin
            probe(3'(s), 1'b0, r); check(r, 1'b0, "R1 parity0");
            probe(3'(s), 1'b1, r); check(r, 1'b1, "R1 parity1");
        end

        // table walk: R2 R3 R5 R8
        for (int i = 0; i < 15; i++) begin
            logic [1:0]  k;
            logic [2:0]  s;
            logic [19:0] v;
            {k, s, v} = VEC[i][25:1];
            case (k)
                2'd0: cycle_ops(1'b1, s, v, 2'b00, 3'd0, 20'd0, 3'd0, 20'd0);
                2'd1: cycle_ops(1'b0, 3'd0, 20'd0, 2'b01, s, v, 3'd0, 20'd0);
                default: cycle_ops(1'b0, 3'd0, 20'd0, 2'b10, 3'd0, 20'd0, s, v);
            endcase
            chk_phase(s, VEC[i][0], "R2/R3 table step");
        end

        // R8 untouched slots keep their phase
        chk_phase(3'd1, 1'b0, "R8 slot1");
        chk_phase(3'd4, 1'b0, "R8 slot4");
        chk_phase(3'd6, 1'b0, "R8 slot6");
        chk_phase(3'd7, 1'b0, "R8 slot7");
        chk_phase(3'd0, 1'b1, "R8 slot0");

        // R5 same-cycle sum on both ports
        cycle_ops(1'b1, 3'd6, 20'd50, 2'b00, 3'd0, 20'd0, 3'd0, 20'd0);
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b11, 3'd6, 20'd25, 3'd6, 20'd24);
        chk_phase(3'd6, 1'b0, "R5 49 of 50");
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b01, 3'd6, 20'd1, 3'd0, 20'd0);
        chk_phase(3'd6, 1'b1, "R5 reach 50");
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b11, 3'd6, 20'd25, 3'd6, 20'd25);
        chk_phase(3'd6, 1'b0, "R5 two ports one cycle");

        // R7 arm and arrival together
        cycle_ops(1'b1, 3'd7, 20'd100, 2'b00, 3'd0, 20'd0, 3'd0, 20'd0);
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b01, 3'd7, 20'd60, 3'd0, 20'd0);
        cycle_ops(1'b1, 3'd7, 20'd500, 2'b01, 3'd7, 20'd40, 3'd0, 20'd0);
        chk_phase(3'd7, 1'b1, "R7 old total used");
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b01, 3'd7, 20'd499, 3'd0, 20'd0);
        chk_phase(3'd7, 1'b1, "R7 new total 499");
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b01, 3'd7, 20'd1, 3'd0, 20'd0);
        chk_phase(3'd7, 1'b0, "R7 new total reached");

        // R6 arm keeps accumulator and phase
        cycle_ops(1'b1, 3'd4, 20'd100, 2'b00, 3'd0, 20'd0, 3'd0, 20'd0);
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b10, 3'd0, 20'd0, 3'd4, 20'd50);
        cycle_ops(1'b1, 3'd4, 20'd80, 2'b00, 3'd0, 20'd0, 3'd0, 20'd0);
        chk_phase(3'd4, 1'b0, "R6 phase after arm");
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b01, 3'd4, 20'd30, 3'd0, 20'd0);
        chk_phase(3'd4, 1'b1, "R6 acc kept");

        // R4 release timing
        cycle_ops(1'b1, 3'd1, 20'd10, 2'b00, 3'd0, 20'd0, 3'd0, 20'd0);
        arr_valid = 2'b01; arr_slot = {3'd0, 3'd1}; arr_bytes = {20'd0, 20'd10};
        probe(3'd1, 1'b0, r); check(r, 1'b0, "R4 before edge");
        tick();
        probe(3'd1, 1'b0, r); check(r, 1'b1, "R4 after edge");
        probe(3'd1, 1'b1, r); check(r, 1'b0, "R4 parity match");

        // R1 reset mid-run clears phases and totals
        rst = 1'b1;
        tick();
        rst = 1'b0;
        for (int s = 0; s < 8; s++) chk_phase(3'(s), 1'b0, "R1 rerun");
        cycle_ops(1'b0, 3'd0, 20'd0, 2'b01, 3'd0, 20'd1, 3'd0, 20'd0);
        chk_phase(3'd0, 1'b1, "R1 total zero");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule